// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block produces the timing strobes that a video encoder needs. It counts pixel clocks within a line and lines within a frame. From those counts it drives these outputs: an active-low horizontal sync, an active-low vertical sync, an active-low composite blank, and an active-low encoder reset that fires once every four fields. All four are retimed on a half-rate data enable, which the block also brings out. Horizontal timing is fixed by parameters. The vertical active window is held in two registers that software can write. The window's reset defaults come from a strap input.

A full reset restores the window defaults and restarts the counters. A separate sync-only reset arms the counters so that they restart on the next falling edge of the incoming vertical sync. The registers are left untouched. A status output tells whether the counters are still in phase with the incoming sync.

Top module: `ilace_sync_gen`

## Requirements
- R1: `pix2_en` is 0 during reset and then alternates every clock. The sync, blank and encoder-reset outputs change only on the clock edge that follows a cycle with `pix2_en` high, and they take the decode of the counter values before that edge.
- R2: A line lasts H_SYNC+H_BP+H_ACT+H_FP clocks (default 58+60+640+22 = 780). Horizontal sync is low while the pixel count is below H_SYNC.
- R3: A frame lasts V_TOTAL lines (default 525). The line count wraps from V_TOTAL-1 to 0. Vertical sync is low while the line count is below V_SYNC (default 2). A 2-bit field counter advances at every wrap.
- R4: Blank is low whenever the pixel count is outside [H_SYNC+H_BP, H_SYNC+H_BP+H_ACT), or the line count is outside [start, end] of the active window, both bounds inclusive.
- R5: At full reset the window loads start 35 / end 514 when `strap_hi` is 0, and 45 / 530 when it is 1 (parameters).
- R6: A write with `reg_we` high stores `reg_wdata` in the start register (`reg_sel`=0) or the end register (`reg_sel`=1). The new value takes effect only at the next frame start. A frame start is a line-count wrap or a resync load.
- R7: The encoder reset is low while the pixel count is below H_SYNC on line 0 of a frame whose field count is 0. Whenever it is low, horizontal and vertical sync are low too.
- R8: A high `sync_rst` arms a resync. At the next falling edge of `vs_in_n`, the pixel, line and field counts restart from 0. The window registers are left unchanged.
- R9: `in_phase` is 0 after reset. At each falling edge of `vs_in_n` it becomes 1 if a resync was armed, or if the counters were at the last pixel of the last line. Otherwise it becomes 0.
- R10: While `rst` is high, all active-low outputs are 1, `pix2_en` is 0, `in_phase` is 0 and the counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous full reset, active high |
| sync_rst | input | 1 | Arms a counter-only resync |
| strap_hi | input | 1 | Selects the window reset defaults |
| vs_in_n | input | 1 | Incoming vertical sync, active low |
| reg_we | input | 1 | Window register write strobe |
| reg_sel | input | 1 | 0 selects the start register, 1 selects the end register |
| reg_wdata | input | V_W | Write data |
| pix2_en | output | 1 | Half-rate data enable |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Composite blank, active low |
| enc_rst_n | output | 1 | Encoder reset, active low |
| in_phase | output | 1 | Counters are aligned with incoming sync |

## Verification
The bench runs the block with reduced timing parameters and compares every output on every clock against a behavioural model. It starts with free running over more than four frames, which separates the field-gated encoder reset from plain sync. Window writes placed in the middle of a frame show whether the new value waits for the frame start. An incoming sync that is misaligned, then resynchronised, then shifted again tells the armed load apart from the wrap-point phase test. A final reset with the strap high shows the second set of defaults.

// File: rtl/isg_pkg.sv
package isg_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic blank;
    logic enc;
  } strobes_t;
endpackage

// File: rtl/isg_counters.sv
module isg_counters #(
  parameter int H_TOTAL = 780,
  parameter int V_TOTAL = 525,
  parameter int H_W = 10,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sync_rst,
  input  logic           vs_in_n,
  output logic [H_W-1:0] h_cnt,
  output logic [V_W-1:0] v_cnt,
  output logic [1:0]     field,
  output logic           frame_start,
  output logic           in_phase
);
  logic vs_d, armed, fall, load, h_last, wrap;

  assign fall   = vs_d & ~vs_in_n;
  assign load   = armed & fall;
  assign h_last = (h_cnt == H_W'(H_TOTAL - 1));
  assign wrap   = h_last & (v_cnt == V_W'(V_TOTAL - 1));
  assign frame_start = load | wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_d     <= 1'b1;
      armed    <= 1'b0;
      in_phase <= 1'b0;
      h_cnt    <= '0;
      v_cnt    <= '0;
      field    <= '0;
    end else begin
      vs_d  <= vs_in_n;
      armed <= sync_rst | (armed & ~fall);
      if (fall) in_phase <= armed | wrap;
      if (load) begin
        h_cnt <= '0;
        v_cnt <= '0;
        field <= '0;
      end else if (h_last) begin
        h_cnt <= '0;
        if (wrap) begin
          v_cnt <= '0;
          field <= field + 2'd1;
        end else begin
          v_cnt <= v_cnt + 1'b1;
        end
      end else begin
        h_cnt <= h_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/isg_window.sv
module isg_window #(
  parameter int V_W = 10,
  parameter int VBP_LO = 35,
  parameter int VEND_LO = 514,
  parameter int VBP_HI = 45,
  parameter int VEND_HI = 530
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           strap_hi,
  input  logic           reg_we,
  input  logic           reg_sel,
  input  logic [V_W-1:0] reg_wdata,
  input  logic           frame_start,
  output logic [V_W-1:0] win_start,
  output logic [V_W-1:0] win_end
);
  localparam int NREG = 2;
  logic [V_W-1:0] shadow [NREG];
  logic [V_W-1:0] live   [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [V_W-1:0] DEF_LO = (i == 0) ? V_W'(VBP_LO) : V_W'(VEND_LO);
    localparam logic [V_W-1:0] DEF_HI = (i == 0) ? V_W'(VBP_HI) : V_W'(VEND_HI);
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[i] <= strap_hi ? DEF_HI : DEF_LO;
        live[i]   <= strap_hi ? DEF_HI : DEF_LO;
      end else begin
        if (frame_start) live[i] <= shadow[i];
        if (reg_we && (reg_sel == i[0])) shadow[i] <= reg_wdata;
      end
    end
  end

  assign win_start = live[0];
  assign win_end   = live[1];
endmodule

// File: rtl/isg_retime.sv
module isg_retime
  import isg_pkg::*;
#(
  parameter int H_SYNC = 58,
  parameter int H_BP = 60,
  parameter int H_ACT = 640,
  parameter int V_SYNC = 2,
  parameter int H_W = 10,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] h_cnt,
  input  logic [V_W-1:0] v_cnt,
  input  logic [1:0]     field,
  input  logic [V_W-1:0] win_start,
  input  logic [V_W-1:0] win_end,
  output logic           pix2_en,
  output logic           hs_n,
  output logic           vs_n,
  output logic           blank_n,
  output logic           enc_rst_n
);
  localparam int H_ON  = H_SYNC + H_BP;
  localparam int H_OFF = H_ON + H_ACT;
  strobes_t dec;
  logic h_act, v_act;

  always_comb begin
    h_act     = (h_cnt >= H_W'(H_ON)) && (h_cnt < H_W'(H_OFF));
    v_act     = (v_cnt >= win_start) && (v_cnt <= win_end);
    dec.hs    = h_cnt < H_W'(H_SYNC);
    dec.vs    = v_cnt < V_W'(V_SYNC);
    dec.blank = !(h_act && v_act);
    dec.enc   = (field == 2'd0) && (v_cnt == '0) && dec.hs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix2_en   <= 1'b0;
      hs_n      <= 1'b1;
      vs_n      <= 1'b1;
      blank_n   <= 1'b1;
      enc_rst_n <= 1'b1;
    end else begin
      pix2_en <= ~pix2_en;
      if (pix2_en) begin
        hs_n      <= ~dec.hs;
        vs_n      <= ~dec.vs;
        blank_n   <= ~dec.blank;
        enc_rst_n <= ~dec.enc;
      end
    end
  end
endmodule

// File: rtl/ilace_sync_gen.sv
module ilace_sync_gen #(
  parameter int H_SYNC = 58,
  parameter int H_BP = 60,
  parameter int H_ACT = 640,
  parameter int H_FP = 22,
  parameter int V_TOTAL = 525,
  parameter int V_SYNC = 2,
  parameter int VBP_LO = 35,
  parameter int VEND_LO = 514,
  parameter int VBP_HI = 45,
  parameter int VEND_HI = 530,
  parameter int V_W = $clog2(V_TOTAL) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sync_rst,
  input  logic           strap_hi,
  input  logic           vs_in_n,
  input  logic           reg_we,
  input  logic           reg_sel,
  input  logic [V_W-1:0] reg_wdata,
  output logic           pix2_en,
  output logic           hs_n,
  output logic           vs_n,
  output logic           blank_n,
  output logic           enc_rst_n,
  output logic           in_phase
);
  localparam int H_TOTAL = H_SYNC + H_BP + H_ACT + H_FP;
  localparam int H_W = $clog2(H_TOTAL) + 1;

  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt, win_start, win_end;
  logic [1:0]     field;
  logic           frame_start;

  isg_counters #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_W(H_W), .V_W(V_W)) u_cnt (
    .clk(clk), .rst(rst), .sync_rst(sync_rst), .vs_in_n(vs_in_n),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .field(field),
    .frame_start(frame_start), .in_phase(in_phase));

  isg_window #(.V_W(V_W), .VBP_LO(VBP_LO), .VEND_LO(VEND_LO),
               .VBP_HI(VBP_HI), .VEND_HI(VEND_HI)) u_win (
    .clk(clk), .rst(rst), .strap_hi(strap_hi), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .frame_start(frame_start),
    .win_start(win_start), .win_end(win_end));

  isg_retime #(.H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACT(H_ACT), .V_SYNC(V_SYNC),
               .H_W(H_W), .V_W(V_W)) u_rt (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .v_cnt(v_cnt), .field(field),
    .win_start(win_start), .win_end(win_end), .pix2_en(pix2_en),
    .hs_n(hs_n), .vs_n(vs_n), .blank_n(blank_n), .enc_rst_n(enc_rst_n));
endmodule

// File: rtl/isg_checker.sv
module isg_checker (
  input logic clk,
  input logic rst,
  input logic pix2_en,
  input logic hs_n,
  input logic vs_n,
  input logic blank_n,
  input logic enc_rst_n
);
  // R1
  en_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    pix2_en |=> !pix2_en);

  // R1
  hold_off_en_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pix2_en) |-> ($stable(hs_n) && $stable(vs_n) && $stable(blank_n) && $stable(enc_rst_n)));

  // R7
  enc_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !enc_rst_n |-> (!hs_n && !vs_n));

  // R4
  hsync_blanked_chk: assert property (@(posedge clk) disable iff (rst)
    !hs_n |-> !blank_n);
endmodule

bind ilace_sync_gen isg_checker u_chk (
  .clk(clk), .rst(rst), .pix2_en(pix2_en), .hs_n(hs_n), .vs_n(vs_n),
  .blank_n(blank_n), .enc_rst_n(enc_rst_n));

// File: tb/ilace_sync_gen_tb.sv
module ilace_sync_gen_tb;
  localparam int HS = 4, HBP = 3, HACT = 10, HFP = 3;
  localparam int HT = HS + HBP + HACT + HFP;
  localparam int VT = 12, VS = 2;
  localparam int BLO = 3, ELO = 9, BHI = 4, EHI = 11;
  localparam int VW = $clog2(VT) + 1;

  logic clk = 0, rst = 1, sync_rst = 0, strap_hi = 0, vs_in_n = 1;
  logic reg_we = 0, reg_sel = 0;
  logic [VW-1:0] reg_wdata = '0;
  logic pix2_en, hs_n, vs_n, blank_n, enc_rst_n, in_phase;

  int vectors = 0, errors = 0, cyc = 0;
  bit vs_gen = 0;
  int vs_off = 0;
  string blank_tag = "R4";

  ilace_sync_gen #(.H_SYNC(HS), .H_BP(HBP), .H_ACT(HACT), .H_FP(HFP),
    .V_TOTAL(VT), .V_SYNC(VS), .VBP_LO(BLO), .VEND_LO(ELO),
    .VBP_HI(BHI), .VEND_HI(EHI), .V_W(VW)) u_dut (
    .clk(clk), .rst(rst), .sync_rst(sync_rst), .strap_hi(strap_hi),
    .vs_in_n(vs_in_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pix2_en(pix2_en), .hs_n(hs_n), .vs_n(vs_n), .blank_n(blank_n),
    .enc_rst_n(enc_rst_n), .in_phase(in_phase));

  always #5 clk = ~clk;

  // behavioural reference model
  int mh = 0, mv = 0, mf = 0, mvsd = 1, marm = 0;
  int msh[2], mact[2];
  bit mph = 0, mhs = 1, mvs = 1, mbl = 1, men = 1, minph = 0;

  always @(posedge clk) begin
    if (rst) begin
      mph = 0; mhs = 1; mvs = 1; mbl = 1; men = 1; minph = 0;
      mh = 0; mv = 0; mf = 0; mvsd = 1; marm = 0;
      msh[0] = strap_hi ? BHI : BLO; msh[1] = strap_hi ? EHI : ELO;
      mact[0] = msh[0]; mact[1] = msh[1];
    end else begin
      bit fall, load, wrap;
      fall = (mvsd == 1) && !vs_in_n;
      load = (marm == 1) && fall;
      wrap = (mh == HT - 1) && (mv == VT - 1);
      if (mph) begin
        mhs = !(mh < HS);
        mvs = !(mv < VS);
        mbl = (mh >= HS + HBP) && (mh < HS + HBP + HACT) && (mv >= mact[0]) && (mv <= mact[1]);
        men = !(mf == 0 && mv == 0 && mh < HS);
      end
      mph = !mph;
      if (load || wrap) begin mact[0] = msh[0]; mact[1] = msh[1]; end
      if (reg_we) msh[reg_sel] = int'(reg_wdata);
      if (fall) minph = marm || wrap;
      marm = sync_rst ? 1 : ((marm == 1 && !fall) ? 1 : 0);
      mvsd = vs_in_n;
      if (load) begin mh = 0; mv = 0; mf = 0; end
      else if (mh == HT - 1) begin
        mh = 0;
        if (mv == VT - 1) begin mv = 0; mf = (mf + 1) % 4; end
        else mv = mv + 1;
      end else mh = mh + 1;
    end
  end

  task automatic cmp(input string req, input string nm, input logic act, input logic exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: got %0b expected %0b", req, nm, cyc, act, exp);
    end
  endtask

  // compare every output on every clock, away from the edge
  always @(negedge clk) begin
    cyc++;
    vectors++;
    cmp("R1", "pix2_en", pix2_en, mph);
    cmp("R2", "hs_n", hs_n, mhs);
    cmp("R3", "vs_n", vs_n, mvs);
    cmp(blank_tag, "blank_n", blank_n, mbl);
    cmp("R7", "enc_rst_n", enc_rst_n, men);
    cmp("R9", "in_phase", in_phase, minph);
    vs_in_n <= !(vs_gen && (((cyc + vs_off) % (HT * VT)) < 6));
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reset();
    vectors++;
    if (!(hs_n && vs_n && blank_n && enc_rst_n && !pix2_en && !in_phase)) begin
      errors++;
      $display("FAIL R10 reset outputs: got %b expected 111100",
               {hs_n, vs_n, blank_n, enc_rst_n, pix2_en, in_phase});
    end
  endtask

  task automatic wr(input bit sel, input int val);
    @(negedge clk);
    reg_we <= 1; reg_sel <= sel; reg_wdata <= VW'(val);
    @(negedge clk);
    reg_we <= 0;
  endtask

  initial begin
    run(3);
    chk_reset();
    rst <= 0;
    blank_tag = "R5";
    run(HT * VT * 5);               // R3 R7: more than four frames
    blank_tag = "R6";
    run(HT * 5 + 7);                // mid-frame writes
    wr(0, 5);
    wr(1, 7);
    run(HT * VT * 2);
    blank_tag = "R8";
    vs_off = 37; vs_gen = 1;        // misaligned incoming sync: R9 expects 0
    run(HT * VT * 2);
    @(negedge clk); sync_rst <= 1;
    @(negedge clk); sync_rst <= 0;
    run(HT * VT * 3);               // R8 realigned, R9 expects 1
    vs_off = 50;                    // shift phase: R9 drops
    run(HT * VT * 2);
    vs_gen = 0;
    @(negedge clk); rst <= 1; strap_hi <= 1;
    run(2);
    chk_reset();
    rst <= 0;
    blank_tag = "R5";
    run(HT * VT * 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired: got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule